// File: doc/BRIEF.md
# Framebuffer Scanout Address Generator

This block computes the memory byte address of every pixel that a display path fetches from a framebuffer. Software programs the geometry through a small 32-bit register port. The programmed values are the width and height in pixels, a colour format code, a row pitch in bytes, and two candidate base addresses with a one-bit selector between them. A frame-start pulse samples this configuration. The block then walks the chosen buffer row by row. It presents one address at a time to a downstream fetch unit, which consumes each address with a pixel-advance strobe.

The pixel size comes from the format code. The start of each new row comes from adding the pitch to the start of the previous row, not from the width. Padded and oversized rows are therefore handled with no extra logic. Start-of-frame, end-of-line and end-of-frame markers travel with each address. Two base registers let software prepare the next buffer while the current one is being scanned. The switch happens only at the next frame boundary.

Top module: `fb_scan_addr_gen`

## Requirements
- R1: After reset, the register read port returns width 480 and height 400 in the geometry register, format code 1, buffer select 0 and a pitch of 1440. The pixel output is not valid.
- R2: The register indices are: 0 geometry (width in bits 15:0, height in bits 31:16), 1 format (bits 2:0), 2 buffer select (bit 0), 3 pitch in bytes, 4 base address A, 5 base address B. A written value reads back on the same index. Indices 6 and 7 read as zero.
- R3: Bytes per pixel follow the format code: 0 gives 4, 1 gives 3, 2, 3 and 4 give 2, and any code above 4 gives 4.
- R4: The address presented for row r and column c equals base + r*pitch + c*bytes_per_pixel, modulo 2^ADDR_W.
- R5: A buffer select of 0 scans from base A. A buffer select of 1 scans from base B.
- R6: Base addresses, buffer select, format, geometry and pitch are sampled only at frame start. Writes during a frame do not change the addresses of that frame; they apply from the next frame start.
- R7: pix_sof is high on the first pixel of a frame. pix_eol is high on the last column of each row. pix_eof is high only on the last pixel of the last row.
- R8: The current address holds while pix_adv is low. After the last pixel is consumed, pix_valid drops and pix_adv has no effect until the next frame start.
- R9: A frame-start pulse during a frame restarts the scan at the first pixel.
- R10: A frame start with zero width or zero height leaves pix_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_idx | input | 3 | Register index for writes |
| cfg_wr_data | input | 32 | Register write data |
| cfg_rd_idx | input | 3 | Register index for reads |
| cfg_rd_data | output | 32 | Register read data (combinational) |
| frame_start | input | 1 | Samples the configuration and starts a scan |
| pix_adv | input | 1 | Consumes the presented address |
| pix_valid | output | 1 | An address is presented |
| pix_addr | output | ADDR_W | Byte address of the current pixel |
| pix_sof | output | 1 | First pixel of the frame |
| pix_eol | output | 1 | Last pixel of a row |
| pix_eof | output | 1 | Last pixel of the frame |

## Verification
Full frames are walked with every format code, including an out-of-range code. Each walk uses a pitch larger than the row, so a design that derives rows from the width instead of the pitch shows up at the first row change. A one-pixel-wide frame separates end-of-line from start-of-frame logic, because every pixel is then a last column. Separate scenarios do the following:
- write a new base, select and format in the middle of a frame;
- restart a frame early;
- hold pix_adv low;
- strobe pix_adv after the frame has ended.

These scenarios tell apart a design that samples its configuration at the frame boundary from one that reads it live.

// File: rtl/fbsag_pkg.sv
package fbsag_pkg;
   localparam int DIM_W   = 16;
   localparam int NUM_BUF = 2;
   localparam int IDX_W   = 3;

   localparam logic [IDX_W-1:0] IDX_GEOM   = 3'd0;
   localparam logic [IDX_W-1:0] IDX_FMT    = 3'd1;
   localparam logic [IDX_W-1:0] IDX_SEL    = 3'd2;
   localparam logic [IDX_W-1:0] IDX_PITCH  = 3'd3;
   localparam logic [IDX_W-1:0] IDX_BASE_A = 3'd4;

   typedef enum logic [2:0] {
      PF_ARGB32 = 3'd0,
      PF_RGB24  = 3'd1,
      PF_R5G6B5 = 3'd2,
      PF_R5G5B5 = 3'd3,
      PF_ARGB16 = 3'd4
   } pix_fmt_e;
endpackage

// File: rtl/fbsag_bpp.sv
module fbsag_bpp
   import fbsag_pkg::*;
(
   input  logic [2:0] fmt_code,
   output logic [2:0] bytes_pp
);
   always_comb begin
      case (fmt_code)
         PF_RGB24:                       bytes_pp = 3'd3;
         PF_R5G6B5, PF_R5G5B5, PF_ARGB16: bytes_pp = 3'd2;
         default:                        bytes_pp = 3'd4;
      endcase
   end
endmodule

// File: rtl/fbsag_regs.sv
module fbsag_regs
   import fbsag_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          RST_WIDTH  = 480,
   parameter int          RST_HEIGHT = 400,
   parameter int          RST_PITCH  = 1440,
   parameter int          RST_FMT    = 1,
   parameter logic [31:0] RST_BASE_A = 32'h0,
   parameter logic [31:0] RST_BASE_B = 32'h0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [31:0]       wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [31:0]       rd_data,
   output logic [DIM_W-1:0]  width,
   output logic [DIM_W-1:0]  height,
   output logic [2:0]        fmt,
   output logic              sel,
   output logic [ADDR_W-1:0] pitch,
   output logic [ADDR_W-1:0] base_a,
   output logic [ADDR_W-1:0] base_b
);
   localparam logic [NUM_BUF-1:0][31:0] BASE_RST = {RST_BASE_B, RST_BASE_A};

   logic [ADDR_W-1:0] base_q [NUM_BUF];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         width  <= DIM_W'(RST_WIDTH);
         height <= DIM_W'(RST_HEIGHT);
         fmt    <= 3'(RST_FMT);
         sel    <= 1'b0;
         pitch  <= ADDR_W'(RST_PITCH);
      end else if (wr_en) begin
         case (wr_idx)
            IDX_GEOM:  {height, width} <= wr_data;
            IDX_FMT:   fmt   <= wr_data[2:0];
            IDX_SEL:   sel   <= wr_data[0];
            IDX_PITCH: pitch <= wr_data[ADDR_W-1:0];
            default: ;
         endcase
      end
   end

   for (genvar b = 0; b < NUM_BUF; b++) begin : g_base
      localparam logic [IDX_W-1:0] MY_IDX = IDX_BASE_A + IDX_W'(b);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base_q[b] <= BASE_RST[b][ADDR_W-1:0];
         else if (wr_en && wr_idx == MY_IDX)
            base_q[b] <= wr_data[ADDR_W-1:0];
      end
   end

   assign base_a = base_q[0];
   assign base_b = base_q[1];

   always_comb begin
      case (rd_idx)
         IDX_GEOM:          rd_data = {height, width};
         IDX_FMT:           rd_data = {29'd0, fmt};
         IDX_SEL:           rd_data = {31'd0, sel};
         IDX_PITCH:         rd_data = 32'(pitch);
         IDX_BASE_A:        rd_data = 32'(base_q[0]);
         IDX_BASE_A + 3'd1: rd_data = 32'(base_q[1]);
         default:           rd_data = 32'd0;
      endcase
   end
endmodule

// File: rtl/fbsag_walker.sv
module fbsag_walker
   import fbsag_pkg::*;
#(
   parameter int ADDR_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              pix_adv,
   input  logic [DIM_W-1:0]  cfg_width,
   input  logic [DIM_W-1:0]  cfg_height,
   input  logic [ADDR_W-1:0] cfg_pitch,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [2:0]        cfg_bpp,
   output logic              valid,
   output logic [ADDR_W-1:0] addr,
   output logic              sof,
   output logic              eol,
   output logic              eof,
   output logic [2:0]        frm_bpp
);
   logic [DIM_W-1:0]  col_q, row_q, w_q, h_q;
   logic [ADDR_W-1:0] row_base_q, col_off_q, pitch_q;
   logic [2:0]        bpp_q;
   logic              act_q;
   logic              last_col, last_row;

   assign last_col = (col_q == w_q - DIM_W'(1));
   assign last_row = (row_q == h_q - DIM_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q      <= 1'b0;
         col_q      <= '0;
         row_q      <= '0;
         w_q        <= '0;
         h_q        <= '0;
         row_base_q <= '0;
         col_off_q  <= '0;
         pitch_q    <= '0;
         bpp_q      <= '0;
      end else if (frame_start) begin
         act_q      <= (cfg_width != '0) && (cfg_height != '0);
         col_q      <= '0;
         row_q      <= '0;
         w_q        <= cfg_width;
         h_q        <= cfg_height;
         row_base_q <= cfg_base;
         col_off_q  <= '0;
         pitch_q    <= cfg_pitch;
         bpp_q      <= cfg_bpp;
      end else if (act_q && pix_adv) begin
         if (last_col) begin
            col_q      <= '0;
            col_off_q  <= '0;
            row_q      <= row_q + DIM_W'(1);
            row_base_q <= row_base_q + pitch_q;
            if (last_row) act_q <= 1'b0;
         end else begin
            col_q     <= col_q + DIM_W'(1);
            col_off_q <= col_off_q + ADDR_W'(bpp_q);
         end
      end
   end

   assign valid   = act_q;
   assign addr    = row_base_q + col_off_q;
   assign sof     = act_q && (col_q == '0) && (row_q == '0);
   assign eol     = act_q && last_col;
   assign eof     = act_q && last_col && last_row;
   assign frm_bpp = bpp_q;
endmodule

// File: rtl/fb_scan_addr_gen.sv
module fb_scan_addr_gen
   import fbsag_pkg::*;
#(
   parameter int          ADDR_W     = 32,
   parameter int          RST_WIDTH  = 480,
   parameter int          RST_HEIGHT = 400,
   parameter int          RST_PITCH  = 1440,
   parameter int          RST_FMT    = 1,
   parameter logic [31:0] RST_BASE_A = 32'h0,
   parameter logic [31:0] RST_BASE_B = 32'h0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr_en,
   input  logic [2:0]        cfg_wr_idx,
   input  logic [31:0]       cfg_wr_data,
   input  logic [2:0]        cfg_rd_idx,
   output logic [31:0]       cfg_rd_data,
   input  logic              frame_start,
   input  logic              pix_adv,
   output logic              pix_valid,
   output logic [ADDR_W-1:0] pix_addr,
   output logic              pix_sof,
   output logic              pix_eol,
   output logic              pix_eof
);
   if (ADDR_W < 16 || ADDR_W > 32) begin : g_bad_addr_w
      $error("fb_scan_addr_gen: ADDR_W must lie in 16..32");
   end
   if (RST_FMT < 0 || RST_FMT > 7) begin : g_bad_fmt
      $error("fb_scan_addr_gen: RST_FMT must fit in 3 bits");
   end

   logic [DIM_W-1:0]  r_width, r_height;
   logic [2:0]        r_fmt, r_bpp, frm_bpp;
   logic              r_sel;
   logic [ADDR_W-1:0] r_pitch, r_base_a, r_base_b, chosen_base;

   fbsag_regs #(
      .ADDR_W(ADDR_W), .RST_WIDTH(RST_WIDTH), .RST_HEIGHT(RST_HEIGHT),
      .RST_PITCH(RST_PITCH), .RST_FMT(RST_FMT),
      .RST_BASE_A(RST_BASE_A), .RST_BASE_B(RST_BASE_B)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cfg_wr_en), .wr_idx(cfg_wr_idx), .wr_data(cfg_wr_data),
      .rd_idx(cfg_rd_idx), .rd_data(cfg_rd_data),
      .width(r_width), .height(r_height), .fmt(r_fmt), .sel(r_sel),
      .pitch(r_pitch), .base_a(r_base_a), .base_b(r_base_b)
   );

   fbsag_bpp u_bpp (.fmt_code(r_fmt), .bytes_pp(r_bpp));

   assign chosen_base = r_sel ? r_base_b : r_base_a;

   fbsag_walker #(.ADDR_W(ADDR_W)) u_walk (
      .clk(clk), .rst_n(rst_n),
      .frame_start(frame_start), .pix_adv(pix_adv),
      .cfg_width(r_width), .cfg_height(r_height), .cfg_pitch(r_pitch),
      .cfg_base(chosen_base), .cfg_bpp(r_bpp),
      .valid(pix_valid), .addr(pix_addr), .sof(pix_sof),
      .eol(pix_eol), .eof(pix_eof), .frm_bpp(frm_bpp)
   );
endmodule

// File: rtl/fbsag_chk.sv
module fbsag_chk #(
   parameter int ADDR_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              frame_start,
   input logic              pix_adv,
   input logic              pix_valid,
   input logic [ADDR_W-1:0] pix_addr,
   input logic              pix_eol,
   input logic              pix_eof,
   input logic [2:0]        frm_bpp
);
   // R4
   col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && pix_adv && !pix_eol && !frame_start |=>
         pix_addr == $past(pix_addr) + ADDR_W'($past(frm_bpp)));

   // R8
   hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && !pix_adv && !frame_start |=> pix_valid && $stable(pix_addr));

   // R8
   frame_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && pix_adv && pix_eof && !frame_start |=> !pix_valid);

   // R8
   stay_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_valid && !frame_start |=> !pix_valid);

   // R7
   eof_in_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_eof |-> pix_eol && pix_valid);
endmodule

bind fb_scan_addr_gen fbsag_chk #(.ADDR_W(ADDR_W)) u_fbsag_chk (
   .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pix_adv(pix_adv),
   .pix_valid(pix_valid), .pix_addr(pix_addr), .pix_eol(pix_eol),
   .pix_eof(pix_eof), .frm_bpp(frm_bpp)
);

// File: tb/test_fb_scan_addr_gen.sv
`timescale 1ns/1ps
module test_fb_scan_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_idx = '0;
   logic [31:0] rd_data;
   logic        fs = 1'b0;
   logic        adv = 1'b0;
   logic        valid, sof, eol, eof;
   logic [31:0] addr;
   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fb_scan_addr_gen i_fb_scan_addr_gen (
      .clk(clk), .rst_n(rst_n),
      .cfg_wr_en(wr_en), .cfg_wr_idx(wr_idx), .cfg_wr_data(wr_data),
      .cfg_rd_idx(rd_idx), .cfg_rd_data(rd_data),
      .frame_start(fs), .pix_adv(adv),
      .pix_valid(valid), .pix_addr(addr), .pix_sof(sof),
      .pix_eol(eol), .pix_eof(eof)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int bpp_of(int f);
      if (f == 1) return 3;
      if (f >= 2 && f <= 4) return 2;
      return 4;
   endfunction

   task automatic wr(logic [2:0] i, logic [31:0] d);
      wr_en = 1'b1; wr_idx = i; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(string req, logic [2:0] i, logic [31:0] exp);
      rd_idx = i; #0.5;
      chk(req, "readback", rd_data, exp);
   endtask

   task automatic setup(int w, int h, int pitch, int f, int sel, int ba, int bb);
      wr(3'd0, {16'(h), 16'(w)});
      wr(3'd1, 32'(f));
      wr(3'd2, 32'(sel));
      wr(3'd3, 32'(pitch));
      wr(3'd4, 32'(ba));
      wr(3'd5, 32'(bb));
   endtask

   task automatic pulse_fs();
      fs = 1'b1; tick(); fs = 1'b0;
   endtask

   // walks a whole frame at full rate, checking address and markers (R4, R5, R7, R8)
   task automatic walk(string req, int w, int h, int pitch, int f, int base);
      int bad = 0;
      for (int r = 0; r < h; r++) begin
         for (int c = 0; c < w; c++) begin
            logic [31:0] ea = 32'(base + r*pitch + c*bpp_of(f));
            logic es = (r == 0 && c == 0);
            logic el = (c == w-1);
            logic ef = el && (r == h-1);
            if (!valid || addr !== ea || sof !== es || eol !== el || eof !== ef) begin
               if (bad == 0)
                  $display("FAIL %s pixel r%0d c%0d: actual v=%0b a=%0h s%0b l%0b f%0b expected a=%0h s%0b l%0b f%0b",
                           req, r, c, valid, addr, sof, eol, eof, ea, es, el, ef);
               bad++;
            end
            adv = 1'b1; tick(); adv = 1'b0;
         end
      end
      checks++;
      if (bad != 0) errors++;
      chk("R8", "valid after last pixel", valid, 0);
   endtask

   task automatic t_reset();
      chk("R1", "valid at reset", valid, 0);
      rd_chk("R1", 3'd0, {16'd400, 16'd480});
      rd_chk("R1", 3'd1, 32'd1);
      rd_chk("R1", 3'd2, 32'd0);
      rd_chk("R1", 3'd3, 32'd1440);
   endtask

   task automatic t_regs();
      setup(7, 5, 64, 7, 1, 32'h1234, 32'h5678);
      rd_chk("R2", 3'd0, {16'd5, 16'd7});
      rd_chk("R2", 3'd1, 32'd7);
      rd_chk("R2", 3'd2, 32'd1);
      rd_chk("R2", 3'd3, 32'd64);
      rd_chk("R2", 3'd4, 32'h1234);
      rd_chk("R2", 3'd5, 32'h5678);
      rd_chk("R2", 3'd6, 32'd0);
   endtask

   task automatic t_frames();
      setup(3, 2, 100, 0, 0, 32'h1000, 32'h8000);
      pulse_fs(); walk("R4 R5", 3, 2, 100, 0, 32'h1000);
      setup(4, 3, 40, 1, 1, 32'h1000, 32'h8000);
      pulse_fs(); walk("R3 R5", 4, 3, 40, 1, 32'h8000);
      for (int f = 2; f <= 7; f++) begin
         setup(3, 2, 20, f, 0, 32'h200, 32'h0);
         pulse_fs(); walk("R3", 3, 2, 20, f, 32'h200);
      end
      setup(1, 3, 12, 0, 0, 32'h40, 32'h0);
      pulse_fs(); walk("R7", 1, 3, 12, 0, 32'h40);
   endtask

   task automatic t_midframe();
      setup(2, 2, 50, 0, 0, 32'h3000, 32'h9000);
      pulse_fs();
      adv = 1'b1; tick(); adv = 1'b0;
      wr(3'd2, 32'd1); wr(3'd4, 32'h7700); wr(3'd1, 32'd1); wr(3'd3, 32'd8);
      chk("R6", "addr after mid-frame writes", addr, 32'h3004);
      adv = 1'b1; tick(); adv = 1'b0;
      chk("R6", "row 1 uses old pitch", addr, 32'h3000 + 50);
      pulse_fs();
      chk("R6", "next frame uses base B", addr, 32'h9000);
      adv = 1'b1; tick(); adv = 1'b0;
      chk("R6", "next frame uses new format", addr, 32'h9003);
   endtask

   task automatic t_hold_restart_idle();
      setup(4, 2, 32, 0, 0, 32'h500, 32'h0);
      pulse_fs();
      adv = 1'b1; tick(); tick(); adv = 1'b0;
      tick(); tick();
      chk("R8", "address held without advance", addr, 32'h508);
      adv = 1'b1; tick(); adv = 1'b0;
      pulse_fs();
      chk("R9", "restart addr", addr, 32'h500);
      chk("R9", "restart sof", sof, 1);
      walk("R9", 4, 2, 32, 0, 32'h500);
      adv = 1'b1; tick(); tick(); adv = 1'b0;
      chk("R8", "advance while idle ignored", valid, 0);
      pulse_fs();
      chk("R8", "first pixel after idle advance", addr, 32'h500);
   endtask

   task automatic t_zero();
      wr(3'd0, {16'd3, 16'd0});
      pulse_fs();
      chk("R10", "zero width", valid, 0);
      wr(3'd0, {16'd0, 16'd3});
      pulse_fs();
      chk("R10", "zero height", valid, 0);
   endtask

   initial begin
      #10_000_000;
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_regs();
      t_frames();
      t_midframe();
      t_hold_restart_idle();
      t_zero();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule